// File: doc/BRIEF.md
# DSP-Mode Audio Serial Transmitter

This block turns audio words from a host into a serial bit stream on one data line. An external bit clock and an external frame-sync signal set the timing. Both are brought into the system clock domain and reduced to one-cycle strobes. One strobe marks the edge where data changes, the other the edge where the far end samples it. A frame is made of one phase, or of two phases when that option is set. Each phase has its own word length and its own number of words.

The host writes one word at a time into a holding register. It uses a request/write handshake. Each word moves into the shifter when the word that uses it begins, which frees the holding register for the next word. The frame starts after frame sync becomes active, either at once or one bit later; the two choices give the two DSP timings. If no word is waiting when one is needed, the previous word is sent again and an underrun flag is set. A frame sync that arrives while a frame is still running either restarts the frame and sets a sync-error flag, or is ignored, as configured. Both flags stay set until the transmitter is disabled.

Top module: `dsp_serial_tx`

## Requirements
- R1: After reset, and from one clock after `tx_en` is low, `sdata` is 0, `tx_req` is 0, the holding register is empty and `underrun` and `sync_err` are 0; bit-clock edges then have no effect on `sdata`.
- R2: The word-length codes sit in `cfg_frame[7:5]` (phase 1) and `cfg_frame[23:21]` (phase 2). The codes are 0=8, 1=12, 2=16, 3=20 and 4=24 bits; 5, 6 and 7 all mean 32 bits. For a length of L, bits L-1 down to 0 of the host word are sent, MSB first, one bit per bit period.
- R3: The word count minus one sits in `cfg_frame[14:8]` (phase 1) and `cfg_frame[30:24]` (phase 2). A phase sends exactly that field plus one words, back to back.
- R4: `cfg_frame[31]`=1 appends phase 2 after phase 1. With it at 0 the phase-2 fields have no effect: the frame ends after phase 1 and no further word is taken from the holding register.
- R5: A frame starts on an inactive-to-active change of frame sync, seen at two successive sample edges. If `cfg_frame[17:16]` is 0, the first MSB fills the bit period right after the one in which the change was sampled. If the field is nonzero, one bit period of 0 comes first. Outside frames `sdata` is 0.
- R6: With `cfg_clk_pol`=1, data changes on the falling edge of `bclk` and frame sync is sampled on the rising edge; with 0, the edges swap. With `cfg_fs_pol`=1, frame sync is active low; with 0, it is active high.
- R7: `tx_req` is 1 while the block is enabled and the holding register is empty. A `wr_en` pulse while `tx_req` is 1 stores `wr_data`. The stored word moves to the shifter at the start of the word that uses it.
- R8: If the holding register is empty when a word starts, the previous word is sent again and `underrun` goes to 1. It stays at 1 until `tx_en` is low.
- R9: When `cfg_frame[18]`=0, a frame-sync change that arrives while a frame is in progress sets `sync_err`. In progress means in the delay bit or in any bit except the last. `sync_err` stays at 1 until `tx_en` is low. The frame restarts at the next change edge with a fresh word, using the same delay rule as R5.
- R10: When `cfg_frame[18]`=1, such a frame-sync change has no effect: the frame completes unchanged and `sync_err` stays 0.
- R11: A frame-sync change sampled during the last bit of a frame starts the next frame with no gap and does not set `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmitter enable; low clears the framing state, holding register and flags |
| cfg_frame | input | 32 | Frame configuration word (fields per R2 to R5, R9, R10) |
| cfg_clk_pol | input | 1 | Bit-clock edge select (R6) |
| cfg_fs_pol | input | 1 | Frame-sync active-low select (R6) |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync |
| wr_en | input | 1 | Host write strobe into the holding register |
| wr_data | input | DATA_W | Host word |
| tx_req | output | 1 | Holding register empty and block enabled |
| sdata | output | 1 | Serial data out |
| underrun | output | 1 | Sticky underrun flag |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
The bench builds the block with its defaults: DATA_W of 32 and two synchronizer stages. These give the full range of word-length codes, up to 32-bit words, and a strobe latency of a few system clocks. The bench drives a bit period of 12 system clocks, so every data change settles well before the far end samples. With this spacing, frame-sync pulses can be placed on any chosen bit period: during the delay bit, in the middle of a word, or on the last bit. That reaches the restart, ignore and back-to-back cases.

// File: rtl/dsp_serial_tx_pkg.sv
package dsp_serial_tx_pkg;

  localparam int unsigned LEN_W = 6;
  localparam int unsigned CNT_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic             dual;
    logic [CNT_W-1:0] cnt2;
    logic [LEN_W-1:0] len2;
    logic             ignore;
    logic             delay1;
    logic [CNT_W-1:0] cnt1;
    logic [LEN_W-1:0] len1;
  } frame_cfg_t;

  function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
    logic [LEN_W-1:0] l;
    case (code)
      3'd0:    l = LEN_W'(8);
      3'd1:    l = LEN_W'(12);
      3'd2:    l = LEN_W'(16);
      3'd3:    l = LEN_W'(20);
      3'd4:    l = LEN_W'(24);
      default: l = LEN_W'(32);
    endcase
    return l;
  endfunction

  function automatic frame_cfg_t decode_cfg(input logic [31:0] w);
    frame_cfg_t c;
    c.len1   = code_to_len(w[7:5]);
    c.cnt1   = w[14:8];
    c.delay1 = |w[17:16];
    c.ignore = w[18];
    c.len2   = code_to_len(w[23:21]);
    c.cnt2   = w[30:24];
    c.dual   = w[31];
    return c;
  endfunction

endpackage

// File: rtl/dsp_tx_edge.sv
module dsp_tx_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fs_in,
  input  logic clk_pol,
  input  logic fs_pol,
  output logic launch_o,
  output logic sample_o,
  output logic fs_act_o
);

  logic [SYNC_STAGES-1:0] bclk_sr;
  logic [SYNC_STAGES-1:0] fs_sr;
  logic                   bclk_prev_q;
  logic                   bclk_s;
  logic                   rise;
  logic                   fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bclk_sr[0] <= 1'b0;
          fs_sr[0]   <= 1'b0;
        end else begin
          bclk_sr[0] <= bclk_in;
          fs_sr[0]   <= fs_in;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bclk_sr[g] <= 1'b0;
          fs_sr[g]   <= 1'b0;
        end else begin
          bclk_sr[g] <= bclk_sr[g-1];
          fs_sr[g]   <= fs_sr[g-1];
        end
      end
    end
  end

  assign bclk_s = bclk_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  assign rise     = bclk_s & ~bclk_prev_q;
  assign fall     = ~bclk_s & bclk_prev_q;
  assign launch_o = clk_pol ? fall : rise;
  assign sample_o = clk_pol ? rise : fall;
  assign fs_act_o = fs_sr[SYNC_STAGES-1] ^ fs_pol;

endmodule

// File: rtl/dsp_tx_hold.sv
module dsp_tx_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o
);

  logic              full_q, full_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              accept;

  assign req_o  = en & ~full_q;
  assign accept = wr_en & req_o;

  always_comb begin
    full_n = full_q;
    data_n = data_q;
    if (accept) begin
      full_n = 1'b1;
      data_n = wr_data;
    end else if (take) begin
      full_n = 1'b0;
    end
    if (!en) full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      if (accept) data_q <= data_n;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R7
  take_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);

  // R7
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_o) |=> full_q);

  // R1
  off_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !full_q);

endmodule

// File: rtl/dsp_tx_frame.sv
module dsp_tx_frame
  import dsp_serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              launch,
  input  logic              sample,
  input  logic              fs_act,
  input  frame_cfg_t        cfg,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              sdata,
  output logic              underrun,
  output logic              sync_err
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] l);
    if (int'(l) > int'(DATA_W)) return LEN_W'(DATA_W);
    return l;
  endfunction

  tx_state_e         state_q, state_n;
  logic              phase_q, phase_n;
  logic [CNT_W-1:0]  wcnt_q, wcnt_n;
  logic [IDX_W-1:0]  bidx_q, bidx_n;
  logic [DATA_W-1:0] word_q, word_n;
  logic              sdata_q, sdata_n;
  logic              pend_q, pend_n;
  logic              fsprev_q, fsprev_n;
  logic              urun_q, urun_n;
  logic              serr_q, serr_n;

  logic [LEN_W-1:0]  len1_e, len2_e, cur_len, load_len;
  logic [IDX_W-1:0]  ld_idx;
  logic              load;
  logic              fs_edge;
  logic              last_bit;

  assign len1_e   = fit_len(cfg.len1);
  assign len2_e   = fit_len(cfg.len2);
  assign cur_len  = phase_q ? len2_e : len1_e;
  assign fs_edge  = sample & fs_act & ~fsprev_q;
  assign last_bit = (state_q == ST_SHIFT) && (bidx_q == '0) && (wcnt_q == '0)
                    && (phase_q || !cfg.dual);

  always_comb begin
    state_n  = state_q;
    phase_n  = phase_q;
    wcnt_n   = wcnt_q;
    bidx_n   = bidx_q;
    word_n   = word_q;
    sdata_n  = sdata_q;
    pend_n   = pend_q;
    fsprev_n = fsprev_q;
    urun_n   = urun_q;
    serr_n   = serr_q;
    take     = 1'b0;
    load     = 1'b0;
    load_len = len1_e;

    if (sample) begin
      fsprev_n = fs_act;
      if (fs_edge) begin
        if (state_q == ST_IDLE || last_bit) begin
          pend_n = 1'b1;
        end else if (!cfg.ignore) begin
          pend_n = 1'b1;
          serr_n = 1'b1;
        end
      end
    end

    if (launch) begin
      if (pend_q) begin
        pend_n  = 1'b0;
        phase_n = 1'b0;
        wcnt_n  = cfg.cnt1;
        if (cfg.delay1) begin
          state_n = ST_DELAY;
          sdata_n = 1'b0;
        end else begin
          state_n = ST_SHIFT;
          load    = 1'b1;
        end
      end else begin
        case (state_q)
          ST_DELAY: begin
            state_n = ST_SHIFT;
            load    = 1'b1;
          end
          ST_SHIFT: begin
            if (bidx_q != '0) begin
              bidx_n  = IDX_W'(bidx_q - 1'b1);
              sdata_n = word_q[IDX_W'(bidx_q - 1'b1)];
            end else if (wcnt_q != '0) begin
              wcnt_n   = CNT_W'(wcnt_q - 1'b1);
              load     = 1'b1;
              load_len = cur_len;
            end else if (!phase_q && cfg.dual) begin
              phase_n  = 1'b1;
              wcnt_n   = cfg.cnt2;
              load     = 1'b1;
              load_len = len2_e;
            end else begin
              state_n = ST_IDLE;
              sdata_n = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end

    ld_idx = IDX_W'(load_len - 1'b1);
    if (load) begin
      take    = hold_full;
      word_n  = hold_full ? hold_data : word_q;
      urun_n  = urun_q | ~hold_full;
      bidx_n  = ld_idx;
      sdata_n = word_n[ld_idx];
    end

    if (!en) begin
      state_n  = ST_IDLE;
      phase_n  = 1'b0;
      wcnt_n   = '0;
      bidx_n   = '0;
      word_n   = '0;
      sdata_n  = 1'b0;
      pend_n   = 1'b0;
      fsprev_n = 1'b0;
      urun_n   = 1'b0;
      serr_n   = 1'b0;
      take     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= 1'b0;
      wcnt_q   <= '0;
      bidx_q   <= '0;
      word_q   <= '0;
      sdata_q  <= 1'b0;
      pend_q   <= 1'b0;
      fsprev_q <= 1'b0;
      urun_q   <= 1'b0;
      serr_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      phase_q  <= phase_n;
      wcnt_q   <= wcnt_n;
      bidx_q   <= bidx_n;
      word_q   <= word_n;
      sdata_q  <= sdata_n;
      pend_q   <= pend_n;
      fsprev_q <= fsprev_n;
      urun_q   <= urun_n;
      serr_q   <= serr_n;
    end
  end

  assign sdata    = sdata_q;
  assign underrun = urun_q;
  assign sync_err = serr_q;

  // R1
  line_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sdata_q);

  // R2
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (int'(bidx_q) < int'(cur_len)));

  // R7
  take_at_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> launch);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && urun_q) |=> urun_q);

  // R9
  sync_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && serr_q) |=> serr_q);

  // R10
  ignore_keeps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg.ignore && !serr_q) |=> !serr_q);

endmodule

// File: rtl/dsp_serial_tx.sv
module dsp_serial_tx
  import dsp_serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [31:0]       cfg_frame,
  input  logic              cfg_clk_pol,
  input  logic              cfg_fs_pol,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_req,
  output logic              sdata,
  output logic              underrun,
  output logic              sync_err
);

  logic [1:0]        rst_sr;
  logic              rst_s_n;
  logic              launch, sample, fs_act;
  logic              hold_full, take;
  logic [DATA_W-1:0] hold_data;
  frame_cfg_t        cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_s_n = rst_sr[1];

  assign cfg = decode_cfg(cfg_frame);

  dsp_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .bclk_in  (bclk),
    .fs_in    (fsync),
    .clk_pol  (cfg_clk_pol),
    .fs_pol   (cfg_fs_pol),
    .launch_o (launch),
    .sample_o (sample),
    .fs_act_o (fs_act)
  );

  dsp_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (tx_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full_o  (hold_full),
    .data_o  (hold_data),
    .req_o   (tx_req)
  );

  dsp_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .en        (tx_en),
    .launch    (launch),
    .sample    (sample),
    .fs_act    (fs_act),
    .cfg       (cfg),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .sdata     (sdata),
    .underrun  (underrun),
    .sync_err  (sync_err)
  );

endmodule

// File: tb/dsp_serial_tx_bench.sv
module dsp_serial_tx_bench;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en;
  logic [31:0] cfg_frame;
  logic        cfg_clk_pol;
  logic        cfg_fs_pol;
  logic        bclk;
  logic        fsync;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        tx_req, sdata, underrun, sync_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        exp_bit[$];
  int          exp_tag[$];
  logic [31:0] feed_q[$];
  event        smp_ev;

  always #5 clk = ~clk;

  dsp_serial_tx u_dsp_serial_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_frame(cfg_frame),
    .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol), .bclk(bclk),
    .fsync(fsync), .wr_en(wr_en), .wr_data(wr_data), .tx_req(tx_req),
    .sdata(sdata), .underrun(underrun), .sync_err(sync_err)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit per sample edge
  initial begin
    forever begin
      logic e;
      int   t;
      @(smp_ev);
      if (exp_bit.size() == 0) begin e = 1'b0; t = 5; end
      else begin e = exp_bit.pop_front(); t = exp_tag.pop_front(); end
      checks++;
      if (sdata !== e) begin
        fails++;
        $display("FAIL R%0d serial bit: got %b expected %b", t, sdata, e);
      end
    end
  end

  // host feeder
  initial begin
    wr_en = 1'b0;
    wr_data = '0;
    forever begin
      @(negedge clk);
      if (wr_en) wr_en = 1'b0;
      else if (tx_req && feed_q.size() > 0) begin
        wr_data = feed_q.pop_front();
        wr_en = 1'b1;
      end
    end
  end

  function automatic logic [31:0] mk_cfg(bit dual, int l1, int c1, int l2, int c2,
                                         int dly, bit ign);
    logic [31:0] w;
    w = '0;
    w[7:5]   = l1[2:0];
    w[14:8]  = c1[6:0];
    w[17:16] = dly[1:0];
    w[18]    = ign;
    w[23:21] = l2[2:0];
    w[30:24] = c2[6:0];
    w[31]    = dual;
    return w;
  endfunction

  task automatic push_zero(input int n, input int tag);
    for (int i = 0; i < n; i++) begin exp_bit.push_back(1'b0); exp_tag.push_back(tag); end
  endtask

  task automatic push_word(input logic [31:0] v, input int len, input int tag);
    for (int i = len - 1; i >= 0; i--) begin exp_bit.push_back(v[i]); exp_tag.push_back(tag); end
  endtask

  task automatic bit_per(input bit fs_on);
    bclk  = cfg_clk_pol ? 1'b0 : 1'b1;
    fsync = fs_on ? ~cfg_fs_pol : cfg_fs_pol;
    repeat (HALF) @(negedge clk);
    bclk = cfg_clk_pol ? 1'b1 : 1'b0;
    -> smp_ev;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run(input int n, input int fa, input int fb);
    for (int i = 0; i < n; i++) bit_per(i == fa || i == fb);
    checks++;
    if (exp_bit.size() != 0) begin
      fails++;
      $display("FAIL R5 stream length: got %0d unsent expected 0", exp_bit.size());
    end
    exp_bit.delete();
    exp_tag.delete();
  endtask

  task automatic start_test(input logic [31:0] cfg, input logic cpol, input logic fpol);
    tx_en = 1'b0;
    feed_q.delete();
    repeat (2) @(negedge clk);
    cfg_frame   = cfg;
    cfg_clk_pol = cpol;
    cfg_fs_pol  = fpol;
    bclk        = cpol ? 1'b1 : 1'b0;
    fsync       = fpol;
    repeat (6) @(negedge clk);
    tx_en = 1'b1;
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; cfg_frame = '0; cfg_clk_pol = 1'b1;
    cfg_fs_pol = 1'b0; bclk = 1'b1; fsync = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sdata, 1'b0, "R1 sdata after reset");
    check(tx_req, 1'b0, "R1 tx_req after reset");
    check(underrun, 1'b0, "R1 underrun after reset");
    check(sync_err, 1'b0, "R1 sync_err after reset");

    // T1: R2 8-bit words, R3 two words, R5 one-bit delay, R6 falling launch
    start_test(mk_cfg(0, 0, 1, 0, 0, 1, 0), 1'b1, 1'b0);
    feed_q.push_back(32'hFFFF_FFA5); feed_q.push_back(32'h3C);
    push_zero(2, 5);
    push_word(32'hA5, 8, 2);
    push_word(32'h3C, 8, 3);
    push_zero(2, 5);
    run(20, 0, -1);
    check(underrun, 1'b0, "R8 no underrun when fed");
    check(sync_err, 1'b0, "R9 no error on clean frame");
    check(tx_req, 1'b1, "R7 request when holding empty");

    // T2: R4 dual phase, R6 rising launch and active-low sync
    start_test(mk_cfg(1, 1, 0, 2, 1, 0, 0), 1'b0, 1'b1);
    feed_q.push_back(32'hFFFF_FABC); feed_q.push_back(32'h1234); feed_q.push_back(32'hBEEF);
    push_zero(1, 5);
    push_word(32'hABC, 12, 6);
    push_word(32'h1234, 16, 4);
    push_word(32'hBEEF, 16, 4);
    push_zero(2, 5);
    run(47, 0, -1);

    // T3: R4 phase-2 fields ignored when single-phase, R2 20-bit code
    start_test(mk_cfg(0, 3, 0, 5, 3, 0, 0), 1'b1, 1'b0);
    feed_q.push_back(32'h5A5A5); feed_q.push_back(32'h12345);
    push_zero(1, 5);
    push_word(32'h5A5A5, 20, 4);
    push_zero(3, 4);
    run(24, 0, -1);
    check(tx_req, 1'b0, "R4 second word left in holding register");

    // T4: R8 underrun repeats previous 24-bit word
    start_test(mk_cfg(0, 4, 1, 0, 0, 0, 0), 1'b1, 1'b0);
    feed_q.push_back(32'hC3A5F0);
    repeat (4) @(negedge clk);
    check(underrun, 1'b0, "R8 flag clear before frame");
    push_zero(1, 5);
    push_word(32'hC3A5F0, 24, 8);
    push_word(32'hC3A5F0, 24, 8);
    push_zero(1, 5);
    run(50, 0, -1);
    check(underrun, 1'b1, "R8 underrun flag set");
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(underrun, 1'b0, "R8 flag cleared by disable");

    // T5: R11 back-to-back 32-bit frames
    start_test(mk_cfg(0, 5, 0, 0, 0, 0, 0), 1'b1, 1'b0);
    feed_q.push_back(32'h8000_0001); feed_q.push_back(32'h7FFF_FFFE);
    push_zero(1, 5);
    push_word(32'h8000_0001, 32, 11);
    push_word(32'h7FFF_FFFE, 32, 11);
    push_zero(1, 5);
    run(66, 0, 32);
    check(sync_err, 1'b0, "R11 no error on last-bit sync");
    check(underrun, 1'b0, "R11 no underrun back to back");

    // T6: R9 unexpected sync restarts frame with delay
    start_test(mk_cfg(0, 2, 0, 0, 0, 1, 0), 1'b1, 1'b0);
    feed_q.push_back(32'hF0F0); feed_q.push_back(32'h9669);
    push_zero(2, 5);
    push_word(32'hF0F0 >> 10, 6, 9);
    push_zero(1, 9);
    push_word(32'h9669, 16, 9);
    push_zero(2, 9);
    run(27, 0, 7);
    check(sync_err, 1'b1, "R9 sync_err set");
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(sync_err, 1'b0, "R9 sync_err cleared by disable");

    // T7: R10 ignore option
    start_test(mk_cfg(0, 2, 0, 0, 0, 0, 1), 1'b1, 1'b0);
    feed_q.push_back(32'h0FF0);
    push_zero(1, 5);
    push_word(32'h0FF0, 16, 10);
    push_zero(1, 10);
    run(18, 0, 5);
    check(sync_err, 1'b0, "R10 sync_err stays clear");

    // T8: R1 disable mid-frame
    start_test(mk_cfg(0, 0, 3, 0, 0, 0, 0), 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) feed_q.push_back(32'hFF);
    push_zero(1, 5);
    push_word(32'hF, 4, 1);
    run(5, 0, -1);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(sdata, 1'b0, "R1 sdata low after disable");
    check(tx_req, 1'b0, "R1 tx_req low after disable");
    feed_q.delete();
    push_zero(4, 1);
    run(4, 1, -1);

    finish_sim();
  end

endmodule